// File: doc/BRIEF.md
# Vectored Priority Interrupt Front End

This block sits beside a small 8-bit processor core and decides which interrupt the core takes at each instruction boundary. It has five request pins. One is a non-maskable line that needs both a rising edge and a sustained high level. Three are maskable lines with fixed vectors: one is edge-latched and two are level-sensitive. The fifth is a maskable line with no fixed vector, and the interrupting device supplies the restart opcode for it. A global enable flag is set and cleared by strobes from the core's decoder. Three per-line mask bits are written through a control byte, and a status byte can be read back at any time.

All pins pass through two-flop synchronisers. When the core pulses the boundary strobe, the block picks the highest-priority request that is allowed to run. One cycle later it returns a single-cycle accept pulse, a source code and a 16-bit vector. For the non-vectored line it also drives an active-low acknowledge in that same cycle.

Top module: `irq_vector_front`

## Requirements
- R1: After reset the global enable is 0, all three masks are 1, the edge-latch and the non-maskable arm are clear, `take` is 0, `ack_n` is 1 and `sout` is 0.
- R2: The non-maskable line (`src_id` 1, vector 0x0024) wins over every other source. It ignores the global enable and the masks, and it leaves the global enable unchanged. It is accepted at most once per rising edge. A new acceptance needs the line to go low and then high again.
- R3: A synchronised rising edge on `rq_hi` sets the edge-latch even while that line is masked. The latch stays set after the pin falls. The line is accepted (`src_id` 2, vector 0x003C) only with the global enable at 1 and mask bit 2 at 0, and accepting it clears the latch.
- R4: `rq_mid` (`src_id` 3, vector 0x0034, mask bit 1) and `rq_lo` (`src_id` 4, vector 0x002C, mask bit 0) are level-sensitive. They are accepted only if the synchronised pin is high at the boundary.
- R5: Priority among the maskable sources is `rq_hi` first, then `rq_mid`, then `rq_lo`, then `rq_ext`.
- R6: `rq_ext` needs only the global enable. It is accepted with `src_id` 5 and vector 0, and `ack_n` is 0 for exactly the cycle in which `take` is 1.
- R7: Accepting any maskable source clears the global enable. `ie_set` sets it and `ie_clr` clears it, and `ie_clr` wins when both are high.
- R8: On a write, bits 0, 1 and 2 of `mw_data` set the masks of `rq_lo`, `rq_mid` and `rq_hi`, where 1 means masked. These bits are applied only when bit 3 is 1; otherwise the old masks stay.
- R9: On a write, bit 4 = 1 clears the edge-latch. Bit 6 = 1 loads bit 7 into `sout`, and bit 6 = 0 leaves `sout` unchanged. Bit 5 has no effect.
- R10: `mr_data` shows, from bit 7 down to bit 0: synchronised `sin`, the edge-latch, synchronised `rq_mid`, synchronised `rq_lo`, the global enable, and the masks of `rq_hi`, `rq_mid` and `rq_lo`.
- R11: Requests are evaluated only on a cycle with `boundary` high. `take` is a one-cycle registered pulse in the next cycle. While `take` is 0, `src_id` and `vector` are 0.
- R12: A pin change reaches `mr_data` after two clock edges. An edge reaches the edge-latch, or arms the non-maskable line, after three clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| nmi_pin | input | 1 | Non-maskable request, edge plus level |
| rq_hi | input | 1 | Edge-latched maskable request |
| rq_mid | input | 1 | Level maskable request |
| rq_lo | input | 1 | Level maskable request, lowest vectored |
| rq_ext | input | 1 | Non-vectored maskable request |
| sin | input | 1 | Serial input pin |
| ie_set | input | 1 | Set global enable |
| ie_clr | input | 1 | Clear global enable |
| mw_stb | input | 1 | Control-byte write strobe |
| mw_data | input | 8 | Control byte |
| mr_data | output | 8 | Status byte |
| boundary | input | 1 | Instruction-boundary strobe |
| take | output | 1 | Accept pulse |
| src_id | output | 3 | Accepted source code |
| vector | output | 16 | Accepted vector address |
| ack_n | output | 1 | Active-low acknowledge for rq_ext |
| sout | output | 1 | Serial output bit |

## Verification
The bench drives inputs on falling edges and allows three rising edges after any pin change before it strobes `boundary`. That is two edges for the synchroniser and one for the edge-latch or the non-maskable arm. The accept outputs are due one edge after the boundary strobe, so they are sampled on the next falling edge. Writes and enable strobes show up in `mr_data` on the falling edge after the capturing edge. The latency checks sample `mr_data` one edge early and then on time to confirm the exact cycle counts.

// File: rtl/irq_vector_front.sv
module irq_vector_front #(
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] VEC_NMI     = 16'h0024,
  parameter logic [15:0] VEC_HI      = 16'h003C,
  parameter logic [15:0] VEC_MID     = 16'h0034,
  parameter logic [15:0] VEC_LO      = 16'h002C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nmi_pin,
  input  logic        rq_hi,
  input  logic        rq_mid,
  input  logic        rq_lo,
  input  logic        rq_ext,
  input  logic        sin,
  input  logic        ie_set,
  input  logic        ie_clr,
  input  logic        mw_stb,
  input  logic [7:0]  mw_data,
  output logic [7:0]  mr_data,
  input  logic        boundary,
  output logic        take,
  output logic [2:0]  src_id,
  output logic [15:0] vector,
  output logic        ack_n,
  output logic        sout
);
  localparam int NPIN = 6;
  localparam int P_NMI = 0, P_HI = 1, P_MID = 2, P_LO = 3, P_EXT = 4, P_SIN = 5;
  localparam logic [2:0] ID_NONE = 3'd0, ID_NMI = 3'd1, ID_HI = 3'd2,
                         ID_MID = 3'd3, ID_LO = 3'd4, ID_EXT = 3'd5;

  logic [SYNC_STAGES-1:0][NPIN-1:0] pipe;
  logic [NPIN-1:0] lvl;
  logic [1:0]      prev;
  logic            rise_nmi, rise_hi;
  logic            ie, pend_hi, nmi_arm;
  logic [2:0]      mask;
  logic [2:0]      sel_id;
  logic [15:0]     sel_vec;
  logic            accept;
  logic            unused_bit5;

  assign unused_bit5 = mw_data[5];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pipe <= '0;
      prev <= '0;
    end else begin
      pipe[0] <= {sin, rq_ext, rq_lo, rq_mid, rq_hi, nmi_pin};
      for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
      prev <= {lvl[P_HI], lvl[P_NMI]};
    end

  assign lvl      = pipe[SYNC_STAGES-1];
  assign rise_nmi = lvl[P_NMI] & ~prev[0];
  assign rise_hi  = lvl[P_HI]  & ~prev[1];

  always_comb begin
    sel_id  = ID_NONE;
    sel_vec = 16'h0000;
    if (nmi_arm && lvl[P_NMI]) begin
      sel_id = ID_NMI;  sel_vec = VEC_NMI;
    end else if (ie && !mask[2] && pend_hi) begin
      sel_id = ID_HI;   sel_vec = VEC_HI;
    end else if (ie && !mask[1] && lvl[P_MID]) begin
      sel_id = ID_MID;  sel_vec = VEC_MID;
    end else if (ie && !mask[0] && lvl[P_LO]) begin
      sel_id = ID_LO;   sel_vec = VEC_LO;
    end else if (ie && lvl[P_EXT]) begin
      sel_id = ID_EXT;
    end
  end

  assign accept = boundary && (sel_id != ID_NONE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ie      <= 1'b0;
      mask    <= 3'b111;
      pend_hi <= 1'b0;
      nmi_arm <= 1'b0;
      sout    <= 1'b0;
      take    <= 1'b0;
      src_id  <= ID_NONE;
      vector  <= 16'h0000;
      ack_n   <= 1'b1;
    end else begin
      if (accept && sel_id != ID_NMI) ie <= 1'b0;
      else if (ie_clr)                ie <= 1'b0;
      else if (ie_set)                ie <= 1'b1;

      if (mw_stb && mw_data[3]) mask <= mw_data[2:0];
      if (mw_stb && mw_data[6]) sout <= mw_data[7];

      if (rise_hi)                                           pend_hi <= 1'b1;
      else if ((mw_stb && mw_data[4]) || (accept && sel_id == ID_HI)) pend_hi <= 1'b0;

      if (!lvl[P_NMI])                       nmi_arm <= 1'b0;
      else if (rise_nmi)                     nmi_arm <= 1'b1;
      else if (accept && sel_id == ID_NMI)   nmi_arm <= 1'b0;

      take   <= accept;
      src_id <= accept ? sel_id  : ID_NONE;
      vector <= accept ? sel_vec : 16'h0000;
      ack_n  <= !(accept && sel_id == ID_EXT);
    end

  assign mr_data = {lvl[P_SIN], pend_hi, lvl[P_MID], lvl[P_LO], ie, mask};
endmodule

// File: rtl/irq_vector_front_chk.sv
module irq_vector_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        boundary,
  input logic        take,
  input logic [2:0]  src_id,
  input logic [15:0] vector,
  input logic        ack_n,
  input logic        rd_ie,
  input logic [2:0]  rd_mask,
  input logic        mw_stb,
  input logic        mw_mse
);
  assert_take_after_boundary_R11: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(boundary));

  assert_idle_outputs_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> (src_id == 3'd0 && vector == 16'h0000));

  assert_ack_only_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> (take && src_id == 3'd5));

  assert_ie_dropped_on_mask_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && src_id >= 3'd2 && src_id <= 3'd5) |-> !rd_ie);

  assert_mask_kept_without_mse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_stb && !mw_mse) |=> $stable(rd_mask));

  assert_nmi_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && src_id == 3'd1) |-> vector == 16'h0024);
endmodule

bind irq_vector_front irq_vector_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .take(take), .src_id(src_id),
  .vector(vector), .ack_n(ack_n), .rd_ie(mr_data[3]), .rd_mask(mr_data[2:0]),
  .mw_stb(mw_stb), .mw_mse(mw_data[3])
);

// File: tb/test_irq_vector_front.sv
`timescale 1ns/1ps
module test_irq_vector_front;
  logic clk = 1'b0, rst_n = 1'b0;
  logic nmi_pin = 0, rq_hi = 0, rq_mid = 0, rq_lo = 0, rq_ext = 0, sin = 0;
  logic ie_set = 0, ie_clr = 0, mw_stb = 0, boundary = 0;
  logic [7:0] mw_data = 8'h00;
  logic [7:0] mr_data;
  logic take, ack_n, sout;
  logic [2:0] src_id;
  logic [15:0] vector;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  irq_vector_front i_irq_vector_front (
    .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .rq_hi(rq_hi), .rq_mid(rq_mid),
    .rq_lo(rq_lo), .rq_ext(rq_ext), .sin(sin), .ie_set(ie_set), .ie_clr(ie_clr),
    .mw_stb(mw_stb), .mw_data(mw_data), .mr_data(mr_data), .boundary(boundary),
    .take(take), .src_id(src_id), .vector(vector), .ack_n(ack_n), .sout(sout)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    mw_stb = 1; mw_data = d; tick(1); mw_stb = 0; mw_data = 8'h00;
  endtask

  task automatic set_ie(input logic v);
    if (v) ie_set = 1; else ie_clr = 1;
    tick(1); ie_set = 0; ie_clr = 0;
  endtask

  task automatic strobe;
    boundary = 1; tick(1); boundary = 0;
  endtask

  function automatic logic [15:0] vec_of(input logic [2:0] id);
    case (id)
      3'd1: return 16'h0024;
      3'd2: return 16'h003C;
      3'd3: return 16'h0034;
      3'd4: return 16'h002C;
      default: return 16'h0000;
    endcase
  endfunction

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(2);
    rst_n = 1;
    tick(1);
    // R1 reset state
    chk("R1 status", mr_data, 8'h07);
    chk("R1 take", take, 0);
    chk("R1 ack_n", ack_n, 1);
    chk("R1 sout", sout, 0);

    // R12 latency of the level path and the edge path
    sin = 1; tick(1);
    chk("R12 sin early", mr_data[7], 0);
    tick(1);
    chk("R12 sin due", mr_data[7], 1);
    sin = 0;
    rq_hi = 1; tick(2);
    chk("R12 latch early", mr_data[6], 0);
    tick(1);
    chk("R12 latch due", mr_data[6], 1);
    rq_hi = 0; tick(3);
    chk("R3 latch held after pin fall", mr_data[6], 1);
    wr(8'h10);
    chk("R9 bit4 clears latch", mr_data[6], 0);

    // sweep: masks x enable x level pins x latch
    for (int m = 0; m < 8; m++)
      for (int e = 0; e < 2; e++)
        for (int lv = 0; lv < 8; lv++)
          for (int p = 0; p < 2; p++) begin
            logic l_mid, l_lo, l_ext;
            logic [2:0] exp_id;
            l_mid = lv[2]; l_lo = lv[1]; l_ext = lv[0];
            rq_mid = 0; rq_lo = 0; rq_ext = 0; rq_hi = 0;
            tick(3);
            wr(8'h18 | 8'(m));
            set_ie(e[0]);
            rq_mid = l_mid; rq_lo = l_lo; rq_ext = l_ext; rq_hi = p[0];
            tick(3);
            rq_hi = 0;
            tick(1);
            chk("R10 status byte", mr_data,
                {1'b0, p[0], l_mid, l_lo, e[0], 3'(m)});
            exp_id = 3'd0;
            if      (e[0] && !m[2] && p[0]) exp_id = 3'd2;
            else if (e[0] && !m[1] && l_mid) exp_id = 3'd3;
            else if (e[0] && !m[0] && l_lo)  exp_id = 3'd4;
            else if (e[0] && l_ext)          exp_id = 3'd5;
            strobe();
            chk("R5 take", take, exp_id != 0);
            chk("R5 src_id (R3 R4 R6)", src_id, exp_id);
            chk("R5 vector", vector, vec_of(exp_id));
            chk("R6 ack_n", ack_n, exp_id != 3'd5);
            tick(1);
            chk("R11 take one cycle", take, 0);
            chk("R7 enable after accept", mr_data[3], exp_id != 0 ? 1'b0 : e[0]);
            chk("R3 latch after accept", mr_data[6], exp_id == 3'd2 ? 1'b0 : p[0]);
          end
    rq_mid = 0; rq_lo = 0; rq_ext = 0;
    tick(3);

    // R11 no evaluation without boundary
    wr(8'h08); set_ie(1); rq_lo = 1;
    for (int k = 0; k < 6; k++) begin
      tick(1);
      chk("R11 no boundary no take", take, 0);
    end
    rq_lo = 0; tick(3);

    // R7 clear wins over set
    ie_set = 1; ie_clr = 1; tick(1); ie_set = 0; ie_clr = 0;
    chk("R7 clear wins", mr_data[3], 0);

    // R2 non-maskable
    set_ie(1); wr(8'h18); rq_hi = 1; tick(3); rq_hi = 0;
    nmi_pin = 1; tick(3);
    strobe();
    chk("R2 nmi take", take, 1);
    chk("R2 nmi id", src_id, 1);
    chk("R2 nmi vector", vector, 16'h0024);
    tick(1);
    chk("R2 enable untouched", mr_data[3], 1);
    chk("R2 latch untouched", mr_data[6], 1);
    strobe();
    chk("R2 no retake while high", src_id, 2);
    wr(8'h0F);
    strobe();
    chk("R2 still high not retaken", take, 0);
    nmi_pin = 0; tick(3); nmi_pin = 1; tick(3);
    strobe();
    chk("R2 retake after new edge masked/disabled", src_id, 1);
    nmi_pin = 0; tick(3);

    // R8 R9 control byte fields
    wr(8'h0A);
    chk("R8 masks applied", mr_data[2:0], 3'b010);
    wr(8'h05);
    chk("R8 masks kept without bit3", mr_data[2:0], 3'b010);
    wr(8'hC0);
    chk("R9 sout loaded", sout, 1);
    chk("R8 masks kept on serial write", mr_data[2:0], 3'b010);
    wr(8'h80);
    chk("R9 sout kept without bit6", sout, 1);
    wr(8'h40);
    chk("R9 sout cleared", sout, 0);
    wr(8'h20);
    chk("R9 bit5 no effect", {sout, mr_data[6:0]}, 8'h02);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule